// File: doc/BRIEF.md
# Memory Pattern Write/Read Self-Test Engine

This block drives a synchronous memory port by itself to test it. Software programs a handful of registers: which directions to run (pattern write, read-and-compare, or both), how many pattern entries one pass covers, the first memory address, and whether the run stops after one pass or repeats. A start command launches the run; the engine then walks the address range, writing a fixed 64-bit pattern or reading it back and comparing.

When both directions are enabled a write pass runs first and the read pass follows at once. Writes are grouped in bursts separated by a short idle gap; reads are issued back to back. Every mismatching read word is counted and the address and both 32-bit halves of the offending word are kept. A stop command, or clearing the control register, halts a run at the next beat.

Top module: `pat_bist`

## Requirements
- R1: After reset the busy bit reads 0, no memory request is made, and the error count, failing address and both failing data halves read 0.
- R2: Register 0 holds write enable (bit 0), read enable (bit 1) and repeat mode (bit 2); register 2 holds the length L; register 3 holds the start offset O. A write pass issues L+1 writes to addresses O+k (modulo the address width), k = 0..L, with data {(k+1)*32'h9E3779B9, 32'h6B43A9B5 ^ (k*32'h01010101)}, both products truncated to 32 bits.
- R3: In a write pass, after every 4th write that is not the last of the pass, the engine spends exactly 2 cycles with no memory request; a read pass has no idle cycles between reads.
- R4: A read pass issues L+1 back-to-back reads to O+k; read data is taken one cycle after the request and compared with the pattern word k. With both enables set, the read pass starts in the cycle right after the last write.
- R5: Bit 0 of register 1 reads 1 for every cycle of a run, gaps included, and clears by itself in the cycle after a single-pass run issues its last access.
- R6: Each mismatching read word raises the error count (register 4), which saturates at all ones, and overwrites the failing address (register 7), failing data high half (register 5) and low half (register 6).
- R7: The first compare of each read pass replaces the previous results, so a read pass reports only its own mismatches.
- R8: With repeat mode set, the engine returns to its first pass after the last one and never ends by itself.
- R9: Writing register 1 with bit 8 set while busy makes the engine idle in the next cycle; no memory request follows.
- R10: Writing all zeroes to register 0 while busy halts the run in the same way as a stop command.
- R11: A start (register 1, bit 0 set, bit 8 clear) while busy has no effect on the ongoing access sequence; a start with neither direction enabled leaves the engine idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 64 | Memory write data |
| mem_rdata_i | input | 64 | Memory read data, one cycle after a read request |

## Verification
The assertions assume the memory returns read data exactly one cycle after a read request and that software leaves the length, offset and direction bits unchanged during a run, other than clearing the control register to halt it. The stimulus only reprograms those registers while the engine is idle, and the bench memory is a one-cycle synchronous array, so stop, clear and repeated-start commands are the only register writes that land mid-run.

// File: rtl/pat_bist_pkg.sv
package pat_bist_pkg;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_GAP, ST_RD} seq_st_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_CMD  = 3'd1;
  localparam logic [2:0] RA_LEN  = 3'd2;
  localparam logic [2:0] RA_OFS  = 3'd3;
  localparam logic [2:0] RA_ERR  = 3'd4;
  localparam logic [2:0] RA_FHI  = 3'd5;
  localparam logic [2:0] RA_FLO  = 3'd6;
  localparam logic [2:0] RA_FADR = 3'd7;

  function automatic logic [DATA_W-1:0] pat_word(input logic [7:0] k);
    logic [31:0] hi;
    hi = 32'h9E3779B9 * ({24'd0, k} + 32'd1);
    return {hi, 32'h6B43A9B5 ^ {4{k}}};
  endfunction
endpackage

// File: rtl/pat_bist_regs.sv
module pat_bist_regs
  import pat_bist_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 4,
  parameter int ERR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic [31:0]       fhi_i,
  input  logic [31:0]       flo_i,
  input  logic [ADDR_W-1:0] fadr_i,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic              cont_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [ADDR_W-1:0] ofs_o,
  output logic              start_o,
  output logic              stop_o
);
  logic [2:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      len_o  <= '0;
      ofs_o  <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_CTRL: ctrl_q <= wdata_i[2:0];
        RA_LEN:  len_o  <= wdata_i[LEN_W-1:0];
        RA_OFS:  ofs_o  <= wdata_i[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  assign wr_en_o = ctrl_q[0];
  assign rd_en_o = ctrl_q[1];
  assign cont_o  = ctrl_q[2];

  assign start_o = we_i && (addr_i == RA_CMD) && wdata_i[0] && !wdata_i[8];
  // stop bit, or a full clear of the control word
  assign stop_o  = we_i && (((addr_i == RA_CMD) && wdata_i[8]) ||
                            ((addr_i == RA_CTRL) && (wdata_i == '0)));

  always_comb begin
    case (addr_i)
      RA_CTRL: rdata_o = {29'd0, ctrl_q};
      RA_CMD:  rdata_o = {31'd0, busy_i};
      RA_LEN:  rdata_o = 32'(len_o);
      RA_OFS:  rdata_o = 32'(ofs_o);
      RA_ERR:  rdata_o = 32'(err_i);
      RA_FHI:  rdata_o = fhi_i;
      RA_FLO:  rdata_o = flo_i;
      default: rdata_o = 32'(fadr_i);
    endcase
  end
endmodule

// File: rtl/pat_bist_seq.sv
module pat_bist_seq
  import pat_bist_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 4,
  parameter int BURST  = 4,
  parameter int GAP    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              cont_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] ofs_i,
  output logic              busy_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  beat_o
);
  localparam int BCW = (BURST > 1) ? $clog2(BURST) : 1;
  localparam int GCW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [BCW-1:0] BLAST = BCW'(BURST - 1);
  localparam logic [GCW-1:0] GLAST = GCW'((GAP > 0) ? GAP - 1 : 0);

  seq_st_e st_q, st_d;
  logic [LEN_W-1:0] beat_q, beat_d;
  logic [BCW-1:0]   bc_q, bc_d;
  logic [GCW-1:0]   gc_q, gc_d;
  logic             last;

  assign last = (beat_q == len_i);

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    bc_d   = bc_q;
    gc_d   = gc_q;
    case (st_q)
      ST_IDLE: if (start_i && (wr_en_i || rd_en_i)) begin
        beat_d = '0;
        bc_d   = '0;
        st_d   = wr_en_i ? ST_WR : ST_RD;
      end
      ST_WR: if (last) begin
        beat_d = '0;
        bc_d   = '0;
        if (rd_en_i)      st_d = ST_RD;
        else if (!cont_i) st_d = ST_IDLE;
      end else begin
        beat_d = beat_q + LEN_W'(1);
        if (bc_q == BLAST && GAP > 0) begin
          bc_d = '0;
          gc_d = '0;
          st_d = ST_GAP;
        end else begin
          bc_d = (bc_q == BLAST) ? '0 : bc_q + BCW'(1);
        end
      end
      ST_GAP: if (gc_q == GLAST) st_d = ST_WR;
              else gc_d = gc_q + GCW'(1);
      ST_RD: if (last) begin
        beat_d = '0;
        bc_d   = '0;
        if (!cont_i)      st_d = ST_IDLE;
        else if (wr_en_i) st_d = ST_WR;
      end else begin
        beat_d = beat_q + LEN_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
    if (stop_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      bc_q   <= '0;
      gc_q   <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      bc_q   <= bc_d;
      gc_q   <= gc_d;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign req_o  = (st_q == ST_WR) || (st_q == ST_RD);
  assign we_o   = (st_q == ST_WR);
  assign addr_o = ofs_i + ADDR_W'(beat_q);
  assign beat_o = beat_q;
endmodule

// File: rtl/pat_bist_cmp.sv
module pat_bist_cmp
  import pat_bist_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 4,
  parameter int ERR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_issue_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  beat_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ERR_W-1:0]  err_o,
  output logic [31:0]       fhi_o,
  output logic [31:0]       flo_o,
  output logic [ADDR_W-1:0] fadr_o
);
  logic              pend_q, first_q;
  logic [ADDR_W-1:0] padr_q;
  logic [LEN_W-1:0]  pbeat_q;
  logic              miss;

  assign miss = pend_q && (rdata_i != pat_word(8'(pbeat_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      first_q <= 1'b0;
      padr_q  <= '0;
      pbeat_q <= '0;
    end else begin
      pend_q  <= rd_issue_i;
      first_q <= rd_issue_i && (beat_i == '0);
      padr_q  <= addr_i;
      pbeat_q <= beat_i;
    end
  end

  // first compare of a pass restarts the results
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o  <= '0;
      fhi_o  <= '0;
      flo_o  <= '0;
      fadr_o <= '0;
    end else if (pend_q) begin
      if (first_q) begin
        err_o  <= miss ? ERR_W'(1) : '0;
        fhi_o  <= miss ? rdata_i[63:32] : '0;
        flo_o  <= miss ? rdata_i[31:0] : '0;
        fadr_o <= miss ? padr_q : '0;
      end else if (miss) begin
        if (!(&err_o)) err_o <= err_o + ERR_W'(1);
        fhi_o  <= rdata_i[63:32];
        flo_o  <= rdata_i[31:0];
        fadr_o <= padr_q;
      end
    end
  end
endmodule

// File: rtl/pat_bist.sv
module pat_bist
  import pat_bist_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 4,
  parameter int ERR_W  = 16,
  parameter int BURST  = 4,
  parameter int GAP    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  input  logic [63:0]       mem_rdata_i
);
  logic              busy, wr_en, rd_en, cont, start, stop;
  logic [LEN_W-1:0]  len, beat;
  logic [ADDR_W-1:0] ofs, fadr;
  logic [ERR_W-1:0]  err_cnt;
  logic [31:0]       fhi, flo;

  pat_bist_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ERR_W(ERR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .busy_i(busy),
    .err_i(err_cnt), .fhi_i(fhi), .flo_i(flo), .fadr_i(fadr),
    .wr_en_o(wr_en), .rd_en_o(rd_en), .cont_o(cont), .len_o(len),
    .ofs_o(ofs), .start_o(start), .stop_o(stop)
  );

  pat_bist_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST(BURST), .GAP(GAP)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .stop_i(stop),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .cont_i(cont), .len_i(len), .ofs_i(ofs),
    .busy_o(busy), .req_o(mem_req_o), .we_o(mem_we_o), .addr_o(mem_addr_o),
    .beat_o(beat)
  );

  pat_bist_cmp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ERR_W(ERR_W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_issue_i(mem_req_o && !mem_we_o),
    .addr_i(mem_addr_o), .beat_i(beat), .rdata_i(mem_rdata_i),
    .err_o(err_cnt), .fhi_o(fhi), .flo_o(flo), .fadr_o(fadr)
  );

  assign mem_wdata_o = pat_word(8'(beat));
endmodule

// File: rtl/pat_bist_chk.sv
module pat_bist_chk #(
  parameter int ERR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             mem_req_o,
  input logic             busy,
  input logic [ERR_W-1:0] err_cnt
);
  // R9
  stop_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd1 && reg_wdata_i[8]) |=> (!busy && !mem_req_o));

  // R10
  ctrl_clear_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd0 && reg_wdata_i == 32'd0) |=> (!busy && !mem_req_o));

  // R5
  req_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy);

  // R6
  err_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + ERR_W'(1) || err_cnt <= ERR_W'(1)));
endmodule

bind pat_bist pat_bist_chk #(.ERR_W(ERR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .mem_req_o(mem_req_o), .busy(busy), .err_cnt(err_cnt)
);

// File: tb/pat_bist_tb_top.sv
module pat_bist_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int LW = 4;
  localparam int EW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          reg_we_i = 1'b0;
  logic [2:0]    reg_addr_i = 3'd1;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [63:0]   mem_wdata_o;
  logic [63:0]   mem_rdata_i = '0;

  pat_bist #(.ADDR_W(AW), .LEN_W(LW), .ERR_W(EW), .BURST(4), .GAP(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  logic [63:0] mem [256];
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o];
    end
  end

  int total = 0;
  int bad = 0;

  typedef struct {bit req; bit we; int addr; logic [63:0] d;} op_t;
  op_t q[$];

  function automatic logic [63:0] ref_pat(int k);
    logic [31:0] h;
    h = 32'(k + 1) * 32'h9E3779B9;
    return {h, 32'h6B43A9B5 ^ (32'(k) * 32'h01010101)};
  endfunction

  task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0; reg_addr_i = 3'd1;
  endtask

  task automatic reg_exp(logic [2:0] a, logic [31:0] e, string r);
    reg_addr_i = a;
    #1;
    chk(reg_rdata_o == e, r, 64'(reg_rdata_o), 64'(e));
    reg_addr_i = 3'd1;
  endtask

  function automatic void add_wr(int len, int ofs);
    for (int b = 0; b <= len; b++) begin
      q.push_back('{1'b1, 1'b1, (ofs + b) % 256, ref_pat(b)});
      if (b % 4 == 3 && b != len) begin
        q.push_back('{1'b0, 1'b0, 0, 64'd0});
        q.push_back('{1'b0, 1'b0, 0, 64'd0});
      end
    end
  endfunction

  function automatic void add_rd(int len, int ofs);
    for (int b = 0; b <= len; b++) q.push_back('{1'b1, 1'b0, (ofs + b) % 256, 64'd0});
  endfunction

  // called at the negedge where the first access is visible
  task automatic run_ops(string r, int inj, logic [2:0] ia, logic [31:0] id, bit halt);
    foreach (q[i]) begin
      chk(mem_req_o == q[i].req, {r, " req"}, 64'(mem_req_o), 64'(q[i].req));
      if (q[i].req) begin
        chk(mem_we_o == q[i].we, {r, " dir"}, 64'(mem_we_o), 64'(q[i].we));
        chk(mem_addr_o == AW'(q[i].addr), {r, " addr"}, 64'(mem_addr_o), 64'(q[i].addr));
        if (q[i].we) chk(mem_wdata_o == q[i].d, {r, " data"}, mem_wdata_o, q[i].d);
      end
      chk(reg_rdata_o[0] == 1'b1, "R5 busy during run", 64'(reg_rdata_o[0]), 64'd1);
      if (i == inj) begin
        reg_wr(ia, id);
        if (halt) break;
      end else begin
        @(negedge clk);
      end
    end
    q.delete();
    chk(!mem_req_o, {r, " idle req"}, 64'(mem_req_o), 64'd0);
    chk(reg_rdata_o[0] == 1'b0, "R5 busy clears", 64'(reg_rdata_o[0]), 64'd0);
    @(negedge clk);
    chk(!mem_req_o, {r, " idle req"}, 64'(mem_req_o), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!mem_req_o, "R1 req", 64'(mem_req_o), 64'd0);
    reg_exp(3'd1, 32'd0, "R1 busy");
    reg_exp(3'd4, 32'd0, "R1 err");
    reg_exp(3'd5, 32'd0, "R1 fhi");
    reg_exp(3'd6, 32'd0, "R1 flo");
    reg_exp(3'd7, 32'd0, "R1 fadr");

    // R2 R3 write pass, 16 entries from 32
    reg_wr(3'd2, 32'd15); reg_wr(3'd3, 32'd32); reg_wr(3'd0, 32'd1);
    reg_wr(3'd1, 32'd1);
    add_wr(15, 32);
    run_ops("R2 R3 write pass", -1, 3'd0, 32'd0, 1'b0);
    chk(mem[40] == ref_pat(8), "R2 stored word", mem[40], ref_pat(8));

    // R4 clean read pass, no gaps
    reg_wr(3'd0, 32'd2); reg_wr(3'd1, 32'd1);
    add_rd(15, 32);
    run_ops("R4 read pass", -1, 3'd0, 32'd0, 1'b0);
    reg_exp(3'd4, 32'd0, "R4 no errors");

    // R6 two corrupted words
    mem[37] = mem[37] ^ 64'h1;
    mem[41] = mem[41] ^ 64'hFF00_0000_0000_00F0;
    reg_wr(3'd1, 32'd1);
    add_rd(15, 32);
    run_ops("R6 read pass", -1, 3'd0, 32'd0, 1'b0);
    reg_exp(3'd4, 32'd2, "R6 err count");
    reg_exp(3'd7, 32'd41, "R6 fail addr");
    reg_exp(3'd5, ref_pat(9) [63:32] ^ 32'hFF00_0000, "R6 fail hi");
    reg_exp(3'd6, ref_pat(9) [31:0] ^ 32'h0000_00F0, "R6 fail lo");

    // R4 R7 write then read, earlier results replaced
    reg_wr(3'd2, 32'd7); reg_wr(3'd3, 32'd100); reg_wr(3'd0, 32'd3);
    reg_wr(3'd1, 32'd1);
    add_wr(7, 100); add_rd(7, 100);
    run_ops("R4 write then read", -1, 3'd0, 32'd0, 1'b0);
    reg_exp(3'd4, 32'd0, "R7 err cleared");
    reg_exp(3'd7, 32'd0, "R7 fadr cleared");

    // R6 saturation: every word bad
    for (int i = 32; i < 48; i++) mem[i] = mem[i] ^ 64'h1;
    reg_wr(3'd2, 32'd15); reg_wr(3'd3, 32'd32); reg_wr(3'd0, 32'd2);
    reg_wr(3'd1, 32'd1);
    add_rd(15, 32);
    run_ops("R6 saturate pass", -1, 3'd0, 32'd0, 1'b0);
    reg_exp(3'd4, 32'd15, "R6 saturated");
    reg_exp(3'd7, 32'd47, "R6 last addr");
    reg_exp(3'd6, ref_pat(15) [31:0] ^ 32'h1, "R6 last lo");

    // R8 R9 repeat write, then stop
    reg_wr(3'd2, 32'd3); reg_wr(3'd3, 32'd200); reg_wr(3'd0, 32'd5);
    reg_wr(3'd1, 32'd1);
    add_wr(3, 200); add_wr(3, 200); add_wr(3, 200);
    run_ops("R8 R9 repeat write stop", 10, 3'd1, 32'h100, 1'b1);

    // R8 R10 repeat read, halted by clearing control
    reg_wr(3'd2, 32'd15); reg_wr(3'd3, 32'd32); reg_wr(3'd0, 32'd6);
    reg_wr(3'd1, 32'd1);
    add_rd(15, 32); add_rd(15, 32);
    run_ops("R8 R10 repeat read clear", 20, 3'd0, 32'd0, 1'b1);

    // R11 start while busy is ignored
    reg_wr(3'd3, 32'd64); reg_wr(3'd0, 32'd1);
    reg_wr(3'd1, 32'd1);
    add_wr(15, 64);
    run_ops("R11 restart ignored", 5, 3'd1, 32'd1, 1'b0);

    // R11 start with no direction enabled
    reg_wr(3'd0, 32'd0);
    reg_wr(3'd1, 32'd1);
    for (int i = 0; i < 3; i++) begin
      chk(!mem_req_o, "R11 no direction req", 64'(mem_req_o), 64'd0);
      chk(reg_rdata_o[0] == 1'b0, "R11 no direction busy", 64'(reg_rdata_o[0]), 64'd0);
      @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule